// File: doc/BRIEF.md
# Byte-Parallel BCH Syndrome Calculator

This block takes a received BCH codeword eight bits per clock and produces the syndromes S1..S2t over GF(2^14). The correction strength is chosen per codeword: t = 8, 16 or 32, with codeword lengths of 8304, 8416 or 8640 bits. For each odd index j the block keeps a running remainder of the received polynomial modulo the minimal polynomial of alpha^j. The remainder register is updated eight bits at a time. When the codeword has fully arrived, each remainder is evaluated at alpha^j with constant multipliers. Even-indexed syndromes are formed by repeated squaring of an odd one.

Only the remainder units needed by the selected strength are clocked. The units above it stay at zero, so a weak mode switches off most of the datapath. A done pulse marks the end of each codeword. A zero flag comes with the done pulse when every syndrome of the word is zero. This lets a downstream key-equation solver and error locator be skipped for clean reads.

Top module: `bch_syndrome`

## Requirements
- R1: For odd j <= 2t-1, syndrome field j equals r(alpha^j). The field is GF(2^14) built from x^14+x^10+x^6+x+1, and alpha is the element x (value 2). The first bit received is the highest-degree coefficient of r(x), and each byte is taken most significant bit first.
- R2: For even j <= 2t, syndrome field j equals the square of field j/2.
- R3: The mode_i encoding is 0 for t=8 with 1038 bytes, 1 for t=16 with 1052 bytes, and 2 or 3 for t=32 with 1080 bytes. The mode is sampled with the first byte of a codeword.
- R4: done_o is a one-cycle pulse in the cycle after the edge that accepts the last byte. The syndromes are valid from that cycle and are held until the first byte of the next codeword is accepted.
- R5: zero_o is high together with done_o exactly when all syndromes S1..S2t are zero. It is low otherwise.
- R6: Syndrome field j occupies syn_o bits [(j-1)*14 +: 14]. Every field with j > 2t reads zero.
- R7: An accepted byte with start_i high begins a new codeword. Any partial remainder and byte count are discarded.
- R8: A cycle with valid_i low has no effect on the result, whatever the values of start_i, data_i and mode_i.
- R9: After reset, done_o and zero_o are low and syn_o is all zero.
- R10: Changes of mode_i after the first byte of a codeword do not affect that codeword or its held result.
- R11: An accepted byte arriving after reset or after a completed codeword begins a new codeword even when start_i is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | data_i carries a codeword byte this cycle |
| start_i | input | 1 | Marks the byte as the first of a codeword |
| mode_i | input | 2 | Correction strength selector |
| data_i | input | 8 | Codeword byte, most significant bit first |
| syn_o | output | 896 | Syndromes S1..S64, 14 bits each |
| zero_o | output | 1 | All syndromes of the finished word are zero |
| done_o | output | 1 | One-cycle pulse when a codeword has been absorbed |

## Verification
The bench compares every syndrome against a direct evaluation of r(alpha^j) computed with its own log tables. This exposes a wrong minimal polynomial, a wrong bit order or a wrong squaring map as mismatching odd or even fields. It builds genuine codewords from generator polynomials of its own. This checks that a t=8 codeword raises zero_o in mode 0 and is judged again under mode 1, so a zero flag that covers the wrong set of units shows up. Further stimulus includes:
- random gaps in valid_i;
- mode_i toggled in the middle of a word;
- an aborted partial word followed by a restart;
- a word begun without start_i.

A counter off by one byte would move done_o. Stale remainders would corrupt the restarted word. Fields above 2t that are not masked would read nonzero.

// File: rtl/bch_syn_pkg.sv
package bch_syn_pkg;
  parameter int GF_M = 14;
  parameter logic [GF_M:0] GF_POLY = 15'h4443;
  parameter int T_MAX = 32;
  parameter int DATA_BITS = 8192;
  parameter int BYTE_W = 8;
  parameter int MODE_W = 2;

  localparam int N_SYN = 2 * T_MAX;
  localparam int N_ODD = T_MAX;
  localparam int GF_ORD = (1 << GF_M) - 1;
  localparam int MAX_BYTES = (DATA_BITS + GF_M * T_MAX) / BYTE_W;
  localparam int CNT_W = $clog2(MAX_BYTES);
  localparam int TW = $clog2(T_MAX + 1);
  localparam int SQ_MAX = $clog2(N_SYN) + 1;

  typedef logic [GF_M-1:0] gf_t;

  // mode 0/1/2 -> T_MAX/4, T_MAX/2, T_MAX; 3 aliases 2
  function automatic logic [TW-1:0] mode_t(logic [MODE_W-1:0] m);
    int lvl;
    lvl = (int'(m) > 2) ? 2 : int'(m);
    return TW'(T_MAX >> (2 - lvl));
  endfunction

  function automatic logic [CNT_W-1:0] mode_last(logic [MODE_W-1:0] m);
    return CNT_W'((DATA_BITS + GF_M * int'(mode_t(m))) / BYTE_W - 1);
  endfunction

  function automatic gf_t gf_xtime(gf_t a);
    return {a[GF_M-2:0], 1'b0} ^ (a[GF_M-1] ? GF_POLY[GF_M-1:0] : '0);
  endfunction

  function automatic gf_t gf_mul(gf_t a, gf_t b);
    gf_t p;
    p = '0;
    for (int i = GF_M - 1; i >= 0; i--) begin
      p = gf_xtime(p);
      if (b[i]) p = p ^ a;
    end
    return p;
  endfunction

  function automatic gf_t gf_sqr_n(gf_t a, int n);
    gf_t r;
    r = a;
    for (int k = 0; k < SQ_MAX; k++) if (k < n) r = gf_mul(r, r);
    return r;
  endfunction

  function automatic gf_t gf_alpha_pow(int e);
    gf_t r;
    gf_t base;
    int x;
    r = gf_t'(1);
    base = gf_t'(2);
    x = e % GF_ORD;
    for (int k = 0; k < GF_M; k++) begin
      if (x[k]) r = gf_mul(r, base);
      base = gf_mul(base, base);
    end
    return r;
  endfunction

  function automatic int coset_size(int j);
    int e0, e, n;
    bit stop;
    e0 = j % GF_ORD;
    e = e0;
    n = 0;
    stop = 1'b0;
    for (int k = 0; k < GF_M; k++) begin
      if (!stop) begin
        n++;
        e = (2 * e) % GF_ORD;
        if (e == e0) stop = 1'b1;
      end
    end
    return n;
  endfunction

  // product of (x + alpha^e) over the cyclotomic coset of j
  function automatic logic [GF_M:0] min_poly(int j);
    logic [GF_M:0][GF_M-1:0] c;
    logic [GF_M:0] res;
    gf_t root;
    int e, n;
    c = '0;
    c[0] = gf_t'(1);
    e = j % GF_ORD;
    n = coset_size(j);
    for (int k = 0; k < GF_M; k++) begin
      if (k < n) begin
        root = gf_alpha_pow(e);
        for (int d = GF_M; d > 0; d--) c[d] = c[d-1] ^ gf_mul(c[d], root);
        c[0] = gf_mul(c[0], root);
        e = (2 * e) % GF_ORD;
      end
    end
    for (int d = 0; d <= GF_M; d++) res[d] = c[d][0];
    return res;
  endfunction

  function automatic logic [GF_M-1:0][GF_M-1:0] eval_basis(int j);
    logic [GF_M-1:0][GF_M-1:0] b;
    for (int k = 0; k < GF_M; k++) b[k] = gf_alpha_pow(j * k);
    return b;
  endfunction

  function automatic int odd_part(int j);
    int x;
    x = j;
    for (int k = 0; k < SQ_MAX; k++) if (x % 2 == 0) x = x / 2;
    return x;
  endfunction

  function automatic int two_exp(int j);
    int x, n;
    x = j;
    n = 0;
    for (int k = 0; k < SQ_MAX; k++) if (x % 2 == 0) begin x = x / 2; n++; end
    return n;
  endfunction
endpackage

// File: rtl/bch_syn_ctrl.sv
module bch_syn_ctrl
  import bch_syn_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              clr_o,
  output logic [TW-1:0]     t_eff_o,
  output logic [TW-1:0]     t_q_o,
  output logic              done_o
);
  logic [CNT_W-1:0]  cnt_q, pos;
  logic [MODE_W-1:0] mode_q, mode_eff;
  logic              first, last, done_q;

  assign first    = valid_i & (start_i | (cnt_q == '0));
  assign mode_eff = first ? mode_i : mode_q;
  assign pos      = start_i ? '0 : cnt_q;
  assign last     = valid_i & (pos == mode_last(mode_eff));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= MODE_W'(2);
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (first) mode_q <= mode_i;
      if (valid_i) cnt_q <= last ? '0 : pos + CNT_W'(1);
    end
  end

  assign clr_o   = first;
  assign t_eff_o = mode_t(mode_eff);
  assign t_q_o   = mode_t(mode_q);
  assign done_o  = done_q;

  a_r4_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r3_done_cnt_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> cnt_q == '0);
  a_r3_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= mode_last(mode_q));
  a_r7_start_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && start_i && !last) |=> cnt_q == CNT_W'(1));
endmodule

// File: rtl/bch_syn_rem.sv
module bch_syn_rem
  import bch_syn_pkg::*;
#(
  parameter int ROOT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              clr_i,
  input  logic              act_i,
  input  logic [BYTE_W-1:0] data_i,
  output gf_t               syn_o,
  output logic              nz_o
);
  localparam logic [GF_M:0] POLY = min_poly(ROOT);
  localparam int DEG = coset_size(ROOT);
  localparam logic [GF_M-1:0][GF_M-1:0] BASIS = eval_basis(ROOT);
  localparam gf_t MASK = gf_t'((1 << DEG) - 1);

  gf_t  rem_q, nxt;
  logic fb;

  // eight serial division steps, msb of the byte first
  always_comb begin
    nxt = clr_i ? '0 : rem_q;
    fb  = 1'b0;
    for (int b = BYTE_W - 1; b >= 0; b--) begin
      fb  = nxt[DEG-1];
      nxt = {nxt[GF_M-2:0], data_i[b]} & MASK;
      if (fb) nxt = nxt ^ (POLY[GF_M-1:0] & MASK);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rem_q <= '0;
    else if (valid_i && act_i)  rem_q <= nxt;
    else if (clr_i)             rem_q <= '0;
  end

  // constant-multiplier evaluation of the remainder at alpha^ROOT
  always_comb begin
    syn_o = '0;
    for (int k = 0; k < GF_M; k++) if (rem_q[k]) syn_o = syn_o ^ BASIS[k];
  end

  assign nz_o = |rem_q;

  a_r6_idle_unit_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_i && !clr_i) |-> rem_q == '0);
endmodule

// File: rtl/bch_syndrome.sv
module bch_syndrome
  import bch_syn_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic                   start_i,
  input  logic [MODE_W-1:0]      mode_i,
  input  logic [BYTE_W-1:0]      data_i,
  output logic [N_SYN*GF_M-1:0]  syn_o,
  output logic                   zero_o,
  output logic                   done_o
);
  logic          clr;
  logic [TW-1:0] t_eff, t_q;
  logic          done;
  gf_t           odd_s [N_ODD];
  logic [N_ODD-1:0] nz;

  bch_syn_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .start_i (start_i),
    .mode_i  (mode_i),
    .clr_o   (clr),
    .t_eff_o (t_eff),
    .t_q_o   (t_q),
    .done_o  (done)
  );

  for (genvar u = 0; u < N_ODD; u++) begin : g_rem
    bch_syn_rem #(.ROOT(2 * u + 1)) u_rem (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (valid_i),
      .clr_i   (clr),
      .act_i   (TW'(u) < t_eff),
      .data_i  (data_i),
      .syn_o   (odd_s[u]),
      .nz_o    (nz[u])
    );
  end

  for (genvar j = 1; j <= N_SYN; j++) begin : g_out
    localparam int ODD = odd_part(j);
    localparam int SH  = two_exp(j);
    assign syn_o[(j-1)*GF_M +: GF_M] =
      (j <= 2 * int'(t_q)) ? gf_sqr_n(odd_s[(ODD-1)/2], SH) : '0;
  end

  // a zero remainder is the only way an odd syndrome can vanish
  assign zero_o = done & ~|nz;
  assign done_o = done;

  a_r5_zero_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |-> done_o);
  a_r5_zero_means_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |-> syn_o == '0);
endmodule

// File: tb/bch_syndrome_tb_top.sv
module bch_syndrome_tb_top;
  localparam int ORD = 16383;
  localparam int NMAX = 8640;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0, start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] data = 8'd0;
  logic [64*14-1:0] syn;
  logic zero, done;

  always #5 clk = ~clk;

  bch_syndrome dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .start_i(start),
    .mode_i(mode), .data_i(data), .syn_o(syn), .zero_o(zero), .done_o(done)
  );

  int alog [0:ORD-1];
  int logt [0:ORD];
  bit cw [0:NMAX-1];
  bit g  [0:511];
  int exp_s [1:64];
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  function automatic int t_of(int m);
    return (m == 0) ? 8 : (m == 1) ? 16 : 32;
  endfunction

  function automatic int gm(int a, int b);
    if (a == 0 || b == 0) return 0;
    return alog[(logt[a] + logt[b]) % ORD];
  endfunction

  function automatic bit [14:0] minpoly(int j);
    int c [0:14];
    int e, deg, root;
    bit [14:0] r;
    for (int i = 0; i <= 14; i++) c[i] = 0;
    c[0] = 1; e = j; deg = 0;
    do begin
      root = alog[e];
      for (int d = deg + 1; d > 0; d--) c[d] = c[d-1] ^ gm(c[d], root);
      c[0] = gm(c[0], root);
      deg++;
      e = (e * 2) % ORD;
    end while (e != j);
    for (int i = 0; i <= 14; i++) r[i] = c[i][0];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic rand_word(input int n);
    for (int i = 0; i < NMAX; i++) cw[i] = (i < n) ? bit'($urandom % 2) : 1'b0;
  endtask

  // codeword = u(x) * product of minimal polynomials of alpha^1..alpha^(2t-1)
  task automatic code_word(input int t);
    int gdeg;
    bit ng [0:511];
    bit [14:0] mp;
    for (int i = 0; i < 512; i++) g[i] = 1'b0;
    g[0] = 1'b1; gdeg = 0;
    for (int j = 1; j < 2 * t; j += 2) begin
      mp = minpoly(j);
      for (int i = 0; i < 512; i++) ng[i] = 1'b0;
      for (int i = 0; i <= gdeg; i++)
        if (g[i]) for (int k = 0; k <= 14; k++) if (mp[k]) ng[i+k] ^= 1'b1;
      g = ng;
      gdeg += 14;
    end
    for (int i = 0; i < NMAX; i++) cw[i] = 1'b0;
    for (int i = 0; i < 8192; i++)
      if ($urandom % 2) for (int k = 0; k <= gdeg; k++) if (g[k]) cw[i+k] ^= 1'b1;
  endtask

  task automatic feed(input int m, input int n, input int cnt, input bit gaps,
                      input bit glitch, input bit use_start);
    int early;
    early = 0;
    for (int k = 0; k < cnt; k++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        @(negedge clk);
        if (done) early++;
        valid = 1'b0; start = 1'($urandom); data = 8'($urandom); mode = 2'($urandom);
      end
      @(negedge clk);
      if (done) early++;
      valid = 1'b1;
      start = (k == 0) && use_start;
      mode  = (k == 0 || !glitch) ? 2'(m) : 2'($urandom);
      for (int b = 0; b < 8; b++) data[7-b] = cw[n - 1 - 8 * k - b];
    end
    chk(early == 0, "R4", "done_o before last byte", early, 0);
  endtask

  task automatic compare_syn(input int t, input string tag);
    int bad_o, bad_e, bad_h, fo, fe, fh;
    bad_o = 0; bad_e = 0; bad_h = 0; fo = 0; fe = 0; fh = 0;
    for (int j = 1; j <= 64; j++) begin
      if (int'(syn[(j-1)*14 +: 14]) != exp_s[j]) begin
        if (j > 2 * t) begin bad_h++; if (fh == 0) fh = j; end
        else if (j % 2) begin bad_o++; if (fo == 0) fo = j; end
        else begin bad_e++; if (fe == 0) fe = j; end
      end
    end
    chk(bad_o == 0, "R1", {tag, " odd syndrome"},
        (fo > 0) ? syn[(fo-1)*14 +: 14] : 0, (fo > 0) ? exp_s[fo] : 0);
    chk(bad_e == 0, "R2", {tag, " even syndrome"},
        (fe > 0) ? syn[(fe-1)*14 +: 14] : 0, (fe > 0) ? exp_s[fe] : 0);
    chk(bad_h == 0, "R6", {tag, " field above 2t"},
        (fh > 0) ? syn[(fh-1)*14 +: 14] : 0, 0);
  endtask

  task automatic finish_word(input int m, input int n, input string tag);
    int t;
    bit allz;
    t = t_of(m);
    allz = 1'b1;
    for (int j = 1; j <= 64; j++) begin
      exp_s[j] = 0;
      if (j <= 2 * t)
        for (int i = 0; i < n; i++) if (cw[i]) exp_s[j] ^= alog[(j * i) % ORD];
      if (exp_s[j] != 0) allz = 1'b0;
    end
    @(negedge clk);
    valid = 1'b0; start = 1'b0;
    chk(done == 1'b1, "R3", {tag, " done_o after last byte"}, done, 1);
    chk(zero == allz, "R5", {tag, " zero_o"}, zero, allz);
    compare_syn(t, tag);
    @(negedge clk);
    chk(done == 1'b0, "R4", {tag, " done_o pulse width"}, done, 0);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    int x;
    x = 1;
    for (int i = 0; i < ORD; i++) begin
      alog[i] = x; logt[x] = i;
      x = x << 1;
      if (x & 16384) x = x ^ 17475;
    end
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(done == 1'b0, "R9", "done_o in reset", done, 0);
    chk(zero == 1'b0, "R9", "zero_o in reset", zero, 0);
    chk(syn == '0, "R9", "syn_o in reset", syn[13:0], 0);
    rst_n = 1'b1;
    @(negedge clk);

    rand_word(8304);  feed(0, 8304, 1038, 0, 0, 1); finish_word(0, 8304, "t8 random");
    rand_word(8416);  feed(1, 8416, 1052, 1, 0, 1); finish_word(1, 8416, "R8 t16 gaps");
    rand_word(8640);  feed(2, 8640, 1080, 0, 0, 1); finish_word(2, 8640, "t32 random");
    // R10 held result does not follow mode_i while idle
    mode = 2'd0;
    repeat (5) @(negedge clk);
    compare_syn(32, "R10 idle hold");
    rand_word(8640);  feed(3, 8640, 1080, 1, 1, 1); finish_word(3, 8640, "R10 mode3 glitch");

    code_word(8);     feed(0, 8304, 1038, 0, 0, 1); finish_word(0, 8304, "R5 t8 codeword");
    feed(1, 8416, 1052, 0, 0, 1);                   finish_word(1, 8416, "t8 codeword in t16");
    code_word(32);    feed(2, 8640, 1080, 1, 0, 1); finish_word(2, 8640, "R5 t32 codeword");

    // R7 abandoned partial word, then restart
    rand_word(8640);  feed(2, 8640, 300, 0, 0, 1);
    rand_word(8304);  feed(0, 8304, 1038, 0, 0, 1); finish_word(0, 8304, "R7 restart");

    rand_word(0);     feed(1, 8416, 1052, 0, 0, 1); finish_word(1, 8416, "R5 all zero");
    // R11 word begun without start_i
    rand_word(8416);  feed(1, 8416, 1052, 1, 0, 0); finish_word(1, 8416, "R11 no start");

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule